// File: doc/BRIEF.md
# Single-Step Opcode Fetch Controller

This block sits between a processor core and a debug front end, and lets the debugger advance the core one instruction at a time. Every cycle the core reports whether it is fetching an opcode. The block passes that flag on as a SYNC output and drives the core's clock enable. A system ready input also feeds the clock enable, so that slow memory can still hold the core off.

In run mode the clock enable follows the external ready and step requests are dropped. In step mode the block stops the core in its opcode-fetch cycle, so the core always freezes at an instruction boundary with SYNC still high. A one-cycle step request then lets exactly one instruction through, and the core stops again at the next fetch. A request that arrives while the core is still executing is held, and it is spent at the next halt. The step-mode input passes through a short register chain, and the decision to grant a fetch is held in a register. Because of this, the clock enable depends combinationally only on the fetch flag, the external ready and registered state, and no path runs through the core model and back.

Top module: `ss_step_ctrl`

## Requirements
- R1: `sync_o` equals `fetch_i` in every cycle, with no register in between.
- R2: While the registered mode is run (including throughout reset), `halted_o` is 0 and `core_en_o` equals `ext_rdy_i`. A step request received in run mode leaves nothing behind: after the switch to step mode the core stays halted at its first fetch.
- R3: In step mode, a fetch cycle without a grant drives `core_en_o` to 0 and `halted_o` to 1. The core then stays frozen with SYNC high for as long as no request arrives.
- R4: A step request sampled in a halted cycle grants the fetch on the next clock. `core_en_o` then goes high, exactly one instruction retires, and the core halts at its next fetch. This also holds when that next fetch follows at once.
- R5: A step request sampled while the core is not halted is held pending. At the next halt the core shows one halted cycle and then retires exactly one more instruction.
- R6: Several step requests received while not halted count as one pending request.
- R7: If `ext_rdy_i` is low while a fetch is granted, `core_en_o` is 0, `halted_o` is 0 and the grant is kept. The instruction retires once `ext_rdy_i` returns high.
- R8: The mode input takes effect after MODE_STAGES rising edges (default 1). When step mode is left while the core is halted, `halted_o` falls and `core_en_o` rises one clock later, and any grant or pending request is dropped.
- R9: The reset `rst_n` is asynchronous and active low, and its release is synchronized internally. After reset the mode is run and no grant or request is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_i | input | 1 | Core flag: this cycle is an opcode fetch |
| ext_rdy_i | input | 1 | System ready; low stalls the core |
| step_mode_i | input | 1 | 1 selects single-step mode, 0 selects run mode |
| step_req_i | input | 1 | One-cycle request to execute one instruction |
| sync_o | output | 1 | Opcode-fetch indicator passed to the system |
| core_en_o | output | 1 | Core clock enable (0 = stall) |
| halted_o | output | 1 | Core is held by the step logic in a fetch cycle |

## Verification
The hardest states to reach are the pending-request paths (R5, R6), because they need the core to be executing, not halted, at the moment the request arrives. When the next fetch follows at once, that window is zero cycles long. The bench's core stub uses execute gaps that vary between zero and three cycles. The bench therefore keeps stepping until the core is caught in an execute cycle. It then pulls the external ready low to freeze the core there, so that requests can be issued at leisure before ready is released.

// File: rtl/ss_pkg.sv
package ss_pkg;
  // Phase of the step logic in the current cycle.
  typedef enum logic [1:0] {
    ST_RUN  = 2'd0,  // run mode, no stepping
    ST_FREE = 2'd1,  // step mode, core executing between fetches
    ST_HALT = 2'd2,  // step mode, fetch held without a grant
    ST_PASS = 2'd3   // step mode, fetch granted
  } ss_phase_e;
endpackage

// File: rtl/ss_rst_sync.sv
module ss_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/ss_mode_reg.sv
module ss_mode_reg #(
  parameter int MODE_STAGES = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mode_i,
  output logic mode_o
);
  logic [MODE_STAGES-1:0] stage_q;
  logic [MODE_STAGES-1:0] stage_d;

  for (genvar g = 0; g < MODE_STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      assign stage_d[g] = mode_i;
    end else begin : g_next
      assign stage_d[g] = stage_q[g-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= '0;
    else        stage_q <= stage_d;
  end

  assign mode_o = stage_q[MODE_STAGES-1];
endmodule

// File: rtl/ss_step_latch.sv
module ss_step_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic mode_i,
  input  logic step_req_i,
  input  logic halted_i,
  output logic pend_o
);
  logic pend_q;
  logic pend_d;
  logic pend_en;

  // A request outside a halt is stored; a halt spends it (the grant logic
  // takes it there). Run mode drops everything.
  always_comb begin
    pend_en = 1'b1;
    if (!mode_i)       pend_d = 1'b0;
    else if (halted_i) pend_d = 1'b0;
    else               pend_d = pend_q | step_req_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pend_q <= 1'b0;
    else if (pend_en) pend_q <= pend_d;
  end

  assign pend_o = pend_q;

  // R6
  pend_spent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && halted_i) |=> !pend_q);
endmodule

// File: rtl/ss_grant.sv
module ss_grant
  import ss_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      mode_i,
  input  logic      sync_i,
  input  logic      ext_rdy_i,
  input  logic      pend_i,
  input  logic      step_req_i,
  output logic      core_en_o,
  output logic      halted_o,
  output logic      pass_o,
  output ss_phase_e phase_o
);
  logic      pass_q;
  logic      pass_d;
  ss_phase_e phase;

  always_comb begin
    if (!mode_i)     phase = ST_RUN;
    else if (!sync_i) phase = ST_FREE;
    else if (pass_q) phase = ST_PASS;
    else             phase = ST_HALT;
  end

  assign halted_o  = (phase == ST_HALT);
  assign core_en_o = ext_rdy_i & (phase != ST_HALT);

  always_comb begin
    unique case (phase)
      ST_RUN:  pass_d = 1'b0;
      ST_HALT: pass_d = pend_i | step_req_i;
      ST_PASS: pass_d = ~ext_rdy_i;   // spent when the fetch completes
      default: pass_d = pass_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pass_q <= 1'b0;
    else        pass_q <= pass_d;
  end

  assign pass_o  = pass_q;
  assign phase_o = phase;

  // R3
  halt_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halted_o |-> !core_en_o);
  // R4
  grant_spent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pass_q && sync_i && core_en_o) |=> !pass_q);
  // R7
  grant_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pass_q && sync_i && !ext_rdy_i) |=> (pass_q || !mode_i));
endmodule

// File: rtl/ss_step_ctrl.sv
module ss_step_ctrl
  import ss_pkg::*;
#(
  parameter int MODE_STAGES = 1,
  parameter int RST_STAGES  = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fetch_i,
  input  logic ext_rdy_i,
  input  logic step_mode_i,
  input  logic step_req_i,
  output logic sync_o,
  output logic core_en_o,
  output logic halted_o
);
  logic      rst_sync_n;
  logic      mode_q;
  logic      pend_q;
  logic      pass_q;
  logic      halted;
  ss_phase_e phase;

  ss_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  ss_mode_reg #(.MODE_STAGES(MODE_STAGES)) u_mode (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .mode_i (step_mode_i),
    .mode_o (mode_q)
  );

  ss_step_latch u_latch (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .mode_i     (mode_q),
    .step_req_i (step_req_i),
    .halted_i   (halted),
    .pend_o     (pend_q)
  );

  ss_grant u_grant (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .mode_i     (mode_q),
    .sync_i     (fetch_i),
    .ext_rdy_i  (ext_rdy_i),
    .pend_i     (pend_q),
    .step_req_i (step_req_i),
    .core_en_o  (core_en_o),
    .halted_o   (halted),
    .pass_o     (pass_q),
    .phase_o    (phase)
  );

  assign sync_o   = fetch_i;
  assign halted_o = halted;

  // R2
  run_passthru_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !mode_q |-> (core_en_o == ext_rdy_i) && !halted_o);
  // R5
  pend_to_grant_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (halted_o && pend_q && mode_q) |=> (pass_q || !mode_q));
  // R8
  mode_release_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $fell(mode_q) |-> !halted_o && !pass_q);
  // R9
  phase_legal_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (phase == ST_PASS) |-> mode_q && sync_o);
endmodule

// File: tb/ss_step_ctrl_tb.sv
module ss_step_ctrl_tb_top;
  logic clk = 1'b0;
  logic rst_n;
  logic ext_rdy, step_mode, step_req;
  logic sync_o, core_en_o, halted_o;
  logic fetch_q;
  int   gap_q;
  int   retired;
  int   n_chk = 0;
  int   n_err = 0;
  bit   done  = 1'b0;

  always #5 clk = ~clk;

  ss_step_ctrl dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .fetch_i     (fetch_q),
    .ext_rdy_i   (ext_rdy),
    .step_mode_i (step_mode),
    .step_req_i  (step_req),
    .sync_o      (sync_o),
    .core_en_o   (core_en_o),
    .halted_o    (halted_o)
  );

  // Core stub: a fetch cycle, then 0..3 execute cycles, advancing only when enabled.
  function automatic int gap_of(int n);
    return (n * 3 + 1) % 4;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fetch_q <= 1'b1;
      gap_q   <= 0;
      retired <= 0;
    end else if (core_en_o) begin
      if (fetch_q) begin
        retired <= retired + 1;
        gap_q   <= gap_of(retired + 1);
        fetch_q <= (gap_of(retired + 1) == 0);
      end else if (gap_q <= 1) begin
        fetch_q <= 1'b1;
      end else begin
        gap_q <= gap_q - 1;
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    #1;
  endtask

  task automatic wait_halt(input string tag);
    int k = 0;
    while (!halted_o && k < 60) begin
      tick();
      k++;
    end
    chk(halted_o == 1'b1, tag, halted_o, 1);
  endtask

  // From a halted cycle: pulse a request, come back at the next halt.
  task automatic step_one(input string tag);
    int base = retired;
    step_req = 1'b1;
    tick();
    step_req = 1'b0;
    chk(core_en_o == 1'b1, {tag, " R4 grant"}, core_en_o, 1);
    wait_halt(tag);
    repeat (6) tick();
    chk(retired == base + 1, {tag, " R4 one instr"}, retired, base + 1);
    chk(sync_o == 1'b1 && core_en_o == 1'b0, {tag, " R3 frozen"}, core_en_o, 0);
  endtask

  // From halted: step until the core is caught executing, then freeze it there.
  task automatic park_in_exec();
    for (int t = 0; t < 8; t++) begin
      step_req = 1'b1;
      tick();
      step_req = 1'b0;
      tick();
      if (!sync_o) break;
    end
    ext_rdy = 1'b0;
    chk(sync_o == 1'b0 && halted_o == 1'b0, "R5 parked in execute", sync_o, 0);
  endtask

  task automatic t_reset();
    chk(halted_o == 1'b0, "R9 halted in reset", halted_o, 0);
    chk(core_en_o == 1'b1, "R2 enable follows ready in reset", core_en_o, 1);
  endtask

  task automatic t_run_mode();
    int base = retired;
    for (int i = 0; i < 20; i++) begin
      step_req = (i % 3 == 0);
      ext_rdy  = (i % 5 != 4);
      tick();
      if (core_en_o != ext_rdy || halted_o || sync_o != fetch_q) begin
        chk(1'b0, "R1/R2 run mode outputs", core_en_o, ext_rdy);
      end
    end
    step_req = 1'b0;
    ext_rdy  = 1'b1;
    chk(1'b1, "R1/R2 run mode outputs", 0, 0);
    chk(retired > base, "R2 core advances", retired, base + 1);
  endtask

  task automatic t_enter_step();
    int base;
    step_mode = 1'b1;
    wait_halt("R3 first halt");
    base = retired;
    repeat (20) tick();
    chk(retired == base, "R2/R3 no retire while halted", retired, base);
    chk(sync_o == 1'b1, "R1/R3 sync held high", sync_o, 1);
    chk(core_en_o == 1'b0, "R3 enable low", core_en_o, 0);
  endtask

  task automatic t_steps();
    for (int i = 0; i < 6; i++) step_one("R4 step");
  endtask

  task automatic t_pending(input int pulses, input string tag);
    int base;
    bit saw_halt = 1'b0;
    park_in_exec();
    base = retired;
    for (int i = 0; i < pulses; i++) begin
      step_req = 1'b1;
      tick();
      step_req = 1'b0;
      tick();
    end
    ext_rdy = 1'b1;
    for (int k = 0; k < 40 && retired < base + 1; k++) begin
      tick();
      if (halted_o) saw_halt = 1'b1;
    end
    chk(saw_halt, {tag, " halted cycle before pending step"}, saw_halt, 1);
    wait_halt(tag);
    repeat (10) tick();
    chk(retired == base + 1, {tag, " exactly one instr"}, retired, base + 1);
  endtask

  task automatic t_ready_low();
    int base = retired;
    step_req = 1'b1;
    ext_rdy  = 1'b0;
    tick();
    step_req = 1'b0;
    repeat (8) tick();
    chk(retired == base, "R7 no retire while ready low", retired, base);
    chk(core_en_o == 1'b0 && halted_o == 1'b0, "R7 granted but stalled", halted_o, 0);
    ext_rdy = 1'b1;
    #0;
    #1;
    chk(core_en_o == 1'b1, "R7 resume", core_en_o, 1);
    wait_halt("R7 halt again");
    repeat (5) tick();
    chk(retired == base + 1, "R7 one instr", retired, base + 1);
  endtask

  task automatic t_leave();
    int base = retired;
    step_mode = 1'b0;
    #1;
    chk(halted_o == 1'b1, "R8 still halted before edge", halted_o, 1);
    tick();
    chk(halted_o == 1'b0 && core_en_o == 1'b1, "R8 released after one clock", core_en_o, 1);
    repeat (10) tick();
    chk(retired > base, "R8 core runs", retired, base + 1);
  endtask

  initial begin
    rst_n = 1'b0;
    ext_rdy = 1'b1;
    step_mode = 1'b0;
    step_req = 1'b0;
    repeat (3) tick();
    t_reset();
    rst_n = 1'b1;
    repeat (4) tick();
    t_run_mode();
    t_enter_step();
    t_steps();
    t_pending(1, "R5");
    t_pending(3, "R6");
    t_ready_low();
    t_leave();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    #200000;
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_err++;
      $display("FAIL watchdog R9 actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule